// File: doc/BRIEF.md
# External Memory Sector Wait-State Sequencer

This block turns single-byte requests from a processor core into read or write cycles on an asynchronous external SRAM bus. A request whose 16-bit address falls inside the external window starts a bus cycle. The block drives the address and raises a read or write strobe, both active high. It keeps the strobe up for a number of cycles that depends on which sector the address falls in. When the strobe drops, it returns a one-cycle acknowledge to the core.

A 3-bit limit code splits the external window at a programmable boundary. Addresses below the boundary form the lower sector and addresses at or above it form the upper sector. Each sector has its own 2-bit wait code. The heaviest wait code also adds one dead cycle after the access, before a new address can go out. The sector decision and the wait code are captured when an access is accepted. A configuration change made while an access is running therefore takes effect on the next access.

Top module: `xmem_sector_seq`

## Requirements
- R1: An address below 0x2200 never starts a bus cycle: no strobe and no acknowledge, however long req_i is held. An address from 0x2200 to 0xFFFF starts one.
- R2: With limit code 000, every external address uses the upper-sector wait code.
- R3: Limit code c from 001 to 110 puts the upper-sector start at (c+1)*0x2000, so 0x4000 for 001 up to 0xE000 for 110. Addresses from 0x2200 to one below that start use the lower-sector wait code. Code 111 behaves like 110.
- R4: The strobe stays high for 1 + W cycles. W is 0 for wait code 00, 1 for 01, 2 for 10 and 2 for 11.
- R5: If req_i is held high, the gap between back-to-back strobes is 2 low cycles. With wait code 11 it is 3 low cycles, which is the added turnaround.
- R6: ack_o is a one-cycle pulse in the cycle right after the strobe falls. The read and write strobes are never high together. ext_addr_o holds steady while a strobe is high.
- R7: For a read, the data at ext_data_i in the last strobe cycle is captured. It appears on rdata_o from the acknowledge cycle onward.
- R8: For a write, ext_data_oe_o is high and ext_data_o carries the write byte for the whole strobe and for one cycle after it.
- R9: Limit and wait codes are sampled when an access is accepted. Changing them during the access does not alter its strobe width or turnaround.
- R10: While rst_ni is low, the strobes, ack_o, ext_data_oe_o, ext_addr_o and rdata_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, level; sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Request address |
| wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | Access done pulse |
| rdata_o | output | 8 | Last read byte |
| cfg_limit_i | input | 3 | Sector limit code |
| cfg_wait_lo_i | input | 2 | Lower-sector wait code |
| cfg_wait_hi_i | input | 2 | Upper-sector wait code |
| ext_addr_o | output | 16 | External address |
| ext_data_o | output | 8 | External write data |
| ext_data_oe_o | output | 1 | External data drive enable |
| ext_data_i | input | 8 | External read data |
| ext_rd_o | output | 1 | Read strobe, active high |
| ext_wr_o | output | 1 | Write strobe, active high |

## Verification
A wrong cycle counter or a wrong sector decision shows up in the strobe width of the access it corrupts. The error appears within at most three strobe cycles of the access starting. A lost turnaround flag shows as a gap between strobes one cycle too short, visible two to three cycles after the acknowledge. A bad data capture point or a bad hold point shows on rdata_o or on the data enable in the acknowledge cycle itself. Each access is therefore judged on its own, before the next one begins.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {S_IDLE, S_STRB, S_POST, S_TURN} xm_state_e;

  // added strobe cycles per wait code
  function automatic logic [1:0] wait_cycles(logic [1:0] code);
    return (code == 2'b11) ? 2'b10 : code;
  endfunction
endpackage

// File: rtl/xmem_sector_decode.sv
module xmem_sector_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LIM_W  = 3,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h2200
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [1:0]        wait_lo_i,
  input  logic [1:0]        wait_hi_i,
  output logic              ext_o,
  output logic [1:0]        wait_code_o
);
  localparam int unsigned SEG_LSB = ADDR_W - LIM_W;

  logic [LIM_W-1:0] seg;
  logic [LIM_W-1:0] start_seg;
  logic             upper;

  assign seg   = addr_i[ADDR_W-1:SEG_LSB];
  assign ext_o = (addr_i >= EXT_BASE);

  // all-ones code saturates to the top segment
  assign start_seg = (limit_i == '1) ? limit_i : limit_i + LIM_W'(1);
  assign upper     = (limit_i == '0) || (seg >= start_seg);

  assign wait_code_o = upper ? wait_hi_i : wait_lo_i;
endmodule

// File: rtl/xmem_strobe_fsm.sv
module xmem_strobe_fsm
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_hit_i,
  input  logic [1:0]        wait_code_i,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o
);
  xm_state_e         state_q;
  logic [1:0]        cnt_q;
  logic              turn_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              strb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      turn_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i && ext_hit_i) begin
          state_q <= S_STRB;
          cnt_q   <= wait_cycles(wait_code_i);
          turn_q  <= (wait_code_i == 2'b11);
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        S_STRB: begin
          if (cnt_q == '0) begin
            state_q <= S_POST;
            if (!we_q) rdata_q <= ext_data_i;
          end else begin
            cnt_q <= cnt_q - 2'd1;
          end
        end
        S_POST: state_q <= turn_q ? S_TURN : S_IDLE;
        S_TURN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign strb          = (state_q == S_STRB);
  assign ext_rd_o      = strb && !we_q;
  assign ext_wr_o      = strb && we_q;
  assign ack_o         = (state_q == S_POST);
  assign ext_data_oe_o = we_q && (strb || state_q == S_POST);
  assign ext_addr_o    = addr_q;
  assign ext_data_o    = wdata_q;
  assign rdata_o       = rdata_q;

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_rd_o && ext_wr_o));
  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R6
  ack_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_rd_o || ext_wr_o) |-> ack_o);
  // R6
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb && $past(strb)) |-> $stable(ext_addr_o));
  // R4
  strobe_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb && $past(strb) && $past(strb, 2)) |=> !strb);
  // R8
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_wr_o) |-> (ext_data_oe_o && $stable(ext_data_o)));
  // R5
  turn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && turn_q) |=> !strb ##1 !strb);
endmodule

// File: rtl/xmem_sector_seq.sv
module xmem_sector_seq #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LIM_W  = 3,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h2200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic [1:0]        cfg_wait_lo_i,
  input  logic [1:0]        cfg_wait_hi_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              ext_rd_o,
  output logic              ext_wr_o
);
  logic       ext_hit;
  logic [1:0] wait_code;

  xmem_sector_decode #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W), .EXT_BASE(EXT_BASE)
  ) u_dec (
    .addr_i     (addr_i),
    .limit_i    (cfg_limit_i),
    .wait_lo_i  (cfg_wait_lo_i),
    .wait_hi_i  (cfg_wait_hi_i),
    .ext_o      (ext_hit),
    .wait_code_o(wait_code)
  );

  xmem_strobe_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .ext_hit_i    (ext_hit),
    .wait_code_i  (wait_code),
    .ext_data_i   (ext_data_i),
    .ack_o        (ack_o),
    .rdata_o      (rdata_o),
    .ext_addr_o   (ext_addr_o),
    .ext_data_o   (ext_data_o),
    .ext_data_oe_o(ext_data_oe_o),
    .ext_rd_o     (ext_rd_o),
    .ext_wr_o     (ext_wr_o)
  );

  // R1
  ext_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rd_o || ext_wr_o) |-> (ext_addr_o >= EXT_BASE));
endmodule

// File: tb/sim_xmem_sector_seq.sv
module sim_xmem_sector_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BOUND [8] = '{16'h0000, 16'h4000, 16'h6000, 16'h8000,
                                        16'hA000, 16'hC000, 16'hE000, 16'hE000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, ext_din = '0;
  logic [2:0]  lim = '0;
  logic [1:0]  wlo = '0, whi = '0;
  logic        ack, oe, rd, wr;
  logic [7:0]  rdata, dout;
  logic [15:0] eaddr;

  int n_cmp = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_sector_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .cfg_limit_i(lim),
    .cfg_wait_lo_i(wlo), .cfg_wait_hi_i(whi), .ext_addr_o(eaddr),
    .ext_data_o(dout), .ext_data_oe_o(oe), .ext_data_i(ext_din),
    .ext_rd_o(rd), .ext_wr_o(wr)
  );

  task automatic chk(string tag, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the acknowledge cycle
  task automatic strobe_meas(input logic [15:0] a, output int w);
    w = 0;
    while (!(rd || wr)) @(negedge clk);
    while (rd || wr) begin
      w++;
      ext_din = 8'(8'hA0 + w);
      if (eaddr != a) chk("R6", int'(eaddr), int'(a), "address during strobe");
      @(negedge clk);
    end
  endtask

  task automatic run_pair(input logic [15:0] a, input logic w_e, input logic [7:0] wd,
                          input int expw, input int expg, input string tag,
                          input bit flip_cfg);
    int w, g;
    @(negedge clk);
    req = 1'b1; addr = a; we = w_e; wdata = wd;
    @(negedge clk);
    if (flip_cfg) begin
      while (!(rd || wr)) @(negedge clk);
      lim = '0; wlo = '0; whi = '0;   // R9 change mid-access
    end
    strobe_meas(a, w);
    chk(tag, w, expw, "strobe width");
    chk("R6", int'(ack), 1, "ack after strobe");
    if (w_e) begin
      chk("R8", int'(oe), 1, "data enable held");
      chk("R8", int'(dout), int'(wd), "write data held");
    end else begin
      chk("R7", int'(rdata), int'(8'hA0 + expw), "read capture");
    end
    g = 0;
    while (!(rd || wr)) begin g++; @(negedge clk); end
    chk(flip_cfg ? "R9" : "R5", g, expg, "gap between strobes");
    strobe_meas(a, w);
    req = 1'b0;
    chk("R6", int'(ack), 1, "second ack");
    @(negedge clk);
    chk("R6", int'(ack), 0, "ack single pulse");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL R6 watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    int hits;
    // R10 reset state
    #(CLK_PERIOD * 2 + 1);
    chk("R10", int'({rd, wr, ack, oe}), 0, "controls in reset");
    chk("R10", int'(eaddr), 0, "address in reset");
    chk("R10", int'(rdata), 0, "rdata in reset");
    @(negedge clk); rst_n = 1'b1;

    // R1 internal address ignored
    @(negedge clk);
    lim = 3'd3; wlo = 2'd3; whi = 2'd3;
    req = 1'b1; we = 1'b1; addr = 16'h21FF; hits = 0;
    repeat (8) begin @(negedge clk); if (rd || wr || ack) hits++; end
    req = 1'b0;
    chk("R1", hits, 0, "no cycle below window");
    run_pair(16'h2200, 1'b0, 8'h00, 3, 3, "R1", 1'b0);

    // every limit code, both wait codes, both sides of the boundary
    for (int l = 0; l < 8; l++)
      for (int lo = 0; lo < 4; lo++)
        for (int hi = 0; hi < 4; hi++)
          for (int side = 0; side < 2; side++) begin
            logic [15:0] a;
            int code;
            if (l == 0) a = side ? 16'hFFFF : 16'h2200;
            else        a = side ? BOUND[l] : BOUND[l] - 16'd1;
            code = (l == 0 || side == 1) ? hi : lo;
            @(negedge clk);
            lim = 3'(l); wlo = 2'(lo); whi = 2'(hi);
            run_pair(a, 1'(side ^ lo), 8'(l * 16 + lo * 4 + hi),
                     1 + ((code == 3) ? 2 : code), (code == 3) ? 3 : 2,
                     (l == 0) ? "R2" : "R3", 1'b0);
          end

    // R4 mid-window address under the lowest upper-start code
    @(negedge clk); lim = 3'd1; wlo = 2'd2; whi = 2'd1;
    run_pair(16'h3FFE, 1'b1, 8'h5C, 3, 2, "R4", 1'b0);

    // R9 config captured at accept
    @(negedge clk); lim = 3'd0; wlo = 2'd0; whi = 2'd3;
    run_pair(16'h3000, 1'b0, 8'h00, 3, 3, "R9", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule